// File: doc/BRIEF.md
# ISA Bus Master Cycle Generator

This block turns single read and write requests from a simple programmed-I/O style requester into ISA bus cycles. A request carries a 24-bit address, a space select (memory or I/O), a direction, a transfer size (one byte or one 16-bit word) and write data. The block accepts a request only while it is idle. It then runs one complete bus cycle and returns a one-clock completion pulse, together with the read data for reads.

The bus clock is a free-running division of the system clock. With the default divide ratio and a 32 MHz system clock it runs at 8 MHz. All bus-side transitions happen on bus-clock boundaries. Each cycle has four phases:

- the address is placed on the latched and unlatched address lines;
- the address latch enable pulses high for one bus clock;
- one of four active-low command strobes is held low for a fixed number of bus clocks;
- the address is held for one more bus clock.

Write data sits on a 16-bit tristate data bus. Byte transfers are steered to the data lane that matches address bit 0.

Top module: `isa_cycle_master`

## Requirements
- R1: `isa_bclk` is periodic with a period of `DIV` system clocks. Counting from reset, it is high for the first `DIV/2` clocks of each period. A "tick" is the last system clock of a period.
- R2: During and after reset, and whenever the block is idle, all four strobes are high, `isa_bale` is low, `isa_sbhe_n` is high, the address outputs are zero and `req_ready` is high.
- R3: A request is taken when `req_valid` is high while `req_ready` is high. `req_ready` falls for the whole cycle. A `req_valid` seen while the block is busy is ignored and starts no cycle.
- R4: After acceptance the address appears at once. At the next tick `isa_bale` rises, and it stays high for exactly one bus clock.
- R5: After the latch-enable bus clock, exactly one strobe is low for `CMD_CLKS` bus clocks. The strobe is chosen by the request: memory write gives `isa_memw_n`, memory read `isa_memr_n`, I/O write `isa_iow_n` and I/O read `isa_ior_n`. No two strobes are ever low together.
- R6: `isa_sa` carries address bits 19:0 and `isa_la` carries address bits 23:17. Both stay stable from acceptance until one bus clock after the strobe rises.
- R7: On writes the data bus is driven from the start of the latch-enable bus clock until one bus clock after the strobe rises. A word drives all 16 bits. A byte at an even address goes on bits 7:0 with bits 15:8 zero. A byte at an odd address goes on bits 15:8 with bits 7:0 zero.
- R8: On reads the data bus is sampled at the tick that ends the last strobe bus clock. For a word, `rsp_rdata` returns all 16 bits. For a byte at an even address it returns bits 7:0, and for a byte at an odd address it returns bits 15:8. In both byte cases the byte is placed in `rsp_rdata[7:0]` with the upper byte zero.
- R9: During a cycle `isa_sbhe_n` is low for word transfers and for byte transfers at an odd address. It is high for byte transfers at an even address.
- R10: `rsp_done` is high for one system clock, at the tick that ends the hold bus clock. `req_ready` is high again in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` |
| isa_bclk | output | 1 | Bus clock |
| isa_bale | output | 1 | Address latch enable |
| isa_sa | output | 20 | Latched system address |
| isa_la | output | 7 | Unlatched address bits 23:17 |
| isa_sbhe_n | output | 1 | Upper byte enable, active low |
| isa_iow_n | output | 1 | I/O write strobe |
| isa_ior_n | output | 1 | I/O read strobe |
| isa_memw_n | output | 1 | Memory write strobe |
| isa_memr_n | output | 1 | Memory read strobe |
| isa_sd | inout | 16 | Bidirectional data bus |

## Verification
The hardest situation to reach is acceptance at each of the `DIV` phases of the bus clock. The phase sets how long the address phase lasts before the latch enable, and so moves every later edge. The stimulus puts idle gaps of different lengths between requests, so that acceptance falls at every phase across the run. A behavioural model advances its own phase counter and is compared on every clock. A second hard case is a request raised while a cycle is in flight. The bench raises `req_valid` with a different address in the middle of a cycle and checks that no second latch-enable pulse or strobe follows.

// File: rtl/isa_master_pkg.sv
package isa_master_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_BALE = 3'd2,
    ST_CMD  = 3'd3,
    ST_HOLD = 3'd4
  } seq_state_e;

  // Place write data on the lane chosen by size and address bit 0.
  function automatic logic [15:0] lane_out(input logic [15:0] d, input logic wide, input logic a0);
    if (wide) return d;
    else if (a0) return {d[7:0], 8'h00};
    else return {8'h00, d[7:0]};
  endfunction

  // Pull read data off the bus lane into the low byte.
  function automatic logic [15:0] lane_in(input logic [15:0] d, input logic wide, input logic a0);
    if (wide) return d;
    else if (a0) return {8'h00, d[15:8]};
    else return {8'h00, d[7:0]};
  endfunction

  // Active-low upper byte enable.
  function automatic logic high_en_n(input logic wide, input logic a0);
    return !(wide || a0);
  endfunction

endpackage

// File: rtl/isa_bclk_gen.sv
module isa_bclk_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic bclk
);
  localparam int unsigned PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;

  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else if (tick) ph <= '0;
    else ph <= ph + 1'b1;
  end

  assign tick = (ph == PW'(DIV - 1));
  assign bclk = (ph < PW'(HALF));
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_master_pkg::*;
#(
  parameter int unsigned CMD_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       accept,
  output seq_state_e state,
  output logic       last_cmd,
  output logic       done
);
  localparam int unsigned CW = $clog2(CMD_CLKS + 1);

  logic [CW-1:0] cnt;

  assign last_cmd = (cnt == CW'(CMD_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) state <= ST_ADDR;
        ST_ADDR: if (tick) state <= ST_BALE;
        ST_BALE: if (tick) begin
          state <= ST_CMD;
          cnt   <= '0;
        end
        ST_CMD: if (tick) begin
          if (last_cmd) state <= ST_HOLD;
          else cnt <= cnt + 1'b1;
        end
        ST_HOLD: if (tick) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isa_data_path.sv
module isa_data_path
  import isa_master_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        in_mem,
  input  logic        in_write,
  input  logic        in_wide,
  input  logic [23:0] in_addr,
  input  logic [15:0] in_wdata,
  input  logic        capture,
  input  logic [15:0] sd_in,
  output logic        cur_mem,
  output logic        cur_write,
  output logic        cur_wide,
  output logic [23:0] cur_addr,
  output logic [15:0] sd_out,
  output logic [15:0] rdata
);
  logic [15:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mem   <= 1'b0;
      cur_write <= 1'b0;
      cur_wide  <= 1'b0;
      cur_addr  <= '0;
      wdata_q   <= '0;
    end else if (accept) begin
      cur_mem   <= in_mem;
      cur_write <= in_write;
      cur_wide  <= in_wide;
      cur_addr  <= in_addr;
      wdata_q   <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (capture) rdata <= lane_in(sd_in, cur_wide, cur_addr[0]);
  end

  assign sd_out = lane_out(wdata_q, cur_wide, cur_addr[0]);
endmodule

// File: rtl/isa_cycle_master.sv
module isa_cycle_master
  import isa_master_pkg::*;
#(
  parameter int unsigned DIV      = 4,
  parameter int unsigned CMD_CLKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_mem,
  input  logic        req_write,
  input  logic        req_wide,
  input  logic [23:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_done,
  output logic [15:0] rsp_rdata,
  output logic        isa_bclk,
  output logic        isa_bale,
  output logic [19:0] isa_sa,
  output logic [6:0]  isa_la,
  output logic        isa_sbhe_n,
  output logic        isa_iow_n,
  output logic        isa_ior_n,
  output logic        isa_memw_n,
  output logic        isa_memr_n,
  inout  wire  [15:0] isa_sd
);
  // named internal events
  logic        bus_tick;
  logic        accept;
  logic        last_cmd;
  logic        strobe_on;
  logic        busy;
  logic        sd_oe;
  logic        capture;
  seq_state_e  state;
  logic        cur_mem, cur_write, cur_wide;
  logic [23:0] cur_addr;
  logic [15:0] sd_out;

  isa_bclk_gen #(.DIV(DIV)) u_bclk (
    .clk (clk),
    .rst_n (rst_n),
    .tick (bus_tick),
    .bclk (isa_bclk)
  );

  isa_cycle_seq #(.CMD_CLKS(CMD_CLKS)) u_seq (
    .clk (clk),
    .rst_n (rst_n),
    .tick (bus_tick),
    .accept (accept),
    .state (state),
    .last_cmd (last_cmd),
    .done (rsp_done)
  );

  isa_data_path u_dp (
    .clk (clk),
    .rst_n (rst_n),
    .accept (accept),
    .in_mem (req_mem),
    .in_write (req_write),
    .in_wide (req_wide),
    .in_addr (req_addr),
    .in_wdata (req_wdata),
    .capture (capture),
    .sd_in (isa_sd),
    .cur_mem (cur_mem),
    .cur_write (cur_write),
    .cur_wide (cur_wide),
    .cur_addr (cur_addr),
    .sd_out (sd_out),
    .rdata (rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = !req_ready;
  assign strobe_on = (state == ST_CMD);
  assign capture   = strobe_on && bus_tick && last_cmd && !cur_write;
  assign sd_oe     = cur_write && (state == ST_BALE || state == ST_CMD || state == ST_HOLD);

  assign isa_bale   = (state == ST_BALE);
  assign isa_sa     = busy ? cur_addr[19:0] : '0;
  assign isa_la     = busy ? cur_addr[23:17] : '0;
  assign isa_sbhe_n = busy ? high_en_n(cur_wide, cur_addr[0]) : 1'b1;

  assign isa_iow_n  = !(strobe_on && !cur_mem &&  cur_write);
  assign isa_ior_n  = !(strobe_on && !cur_mem && !cur_write);
  assign isa_memw_n = !(strobe_on &&  cur_mem &&  cur_write);
  assign isa_memr_n = !(strobe_on &&  cur_mem && !cur_write);

  assign isa_sd = sd_oe ? sd_out : 16'hzzzz;
endmodule

// File: rtl/isa_master_chk.sv
module isa_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        ready,
  input logic        done,
  input logic        bale,
  input logic [19:0] sa,
  input logic [6:0]  la,
  input logic        iow_n,
  input logic        ior_n,
  input logic        memw_n,
  input logic        memr_n,
  input logic        sd_oe
);
  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~iow_n, ~ior_n, ~memw_n, ~memr_n}) <= 1);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (iow_n && ior_n && memw_n && memr_n && !bale));

  assert_bale_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bale && !tick) |=> bale);

  assert_bale_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bale && tick) |=> !bale);

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !$past(ready)) |-> ($stable(sa) && $stable(la)));

  assert_write_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!iow_n || !memw_n) |-> sd_oe);

  assert_read_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ior_n || !memr_n) |-> !sd_oe);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);
endmodule

bind isa_cycle_master isa_master_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .tick (bus_tick),
  .ready (req_ready),
  .done (rsp_done),
  .bale (isa_bale),
  .sa (isa_sa),
  .la (isa_la),
  .iow_n (isa_iow_n),
  .ior_n (isa_ior_n),
  .memw_n (isa_memw_n),
  .memr_n (isa_memr_n),
  .sd_oe (sd_oe)
);

// File: tb/sim_isa_cycle_master.sv
`timescale 1ns/1ps
module sim_isa_cycle_master;
  localparam int DIV = 4;
  localparam int CMD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_mem = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic        isa_bclk, isa_bale, isa_sbhe_n;
  logic        isa_iow_n, isa_ior_n, isa_memw_n, isa_memr_n;
  logic [19:0] isa_sa;
  logic [6:0]  isa_la;
  wire  [15:0] isa_sd;
  logic [15:0] slv_val = 16'h0000;

  assign isa_sd = (!isa_ior_n || !isa_memr_n) ? slv_val : 16'hzzzz;

  always #5 clk = ~clk;

  isa_cycle_master #(.DIV(DIV), .CMD_CLKS(CMD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mem(req_mem), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .isa_bclk(isa_bclk), .isa_bale(isa_bale),
    .isa_sa(isa_sa), .isa_la(isa_la), .isa_sbhe_n(isa_sbhe_n),
    .isa_iow_n(isa_iow_n), .isa_ior_n(isa_ior_n), .isa_memw_n(isa_memw_n),
    .isa_memr_n(isa_memr_n), .isa_sd(isa_sd)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit running = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model: phases 0 idle,1 address,2 latch,3 strobe,4 hold
  int          m_ph, m_st, m_n;
  bit          m_t, m_done, m_mem, m_wr, m_wide;
  logic [23:0] m_addr;
  logic [15:0] m_wd, m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_st = 0; m_n = 0; m_done = 0; m_rd = 0;
      m_mem = 0; m_wr = 0; m_wide = 0; m_addr = 0; m_wd = 0;
    end else begin
      m_t = (m_ph == DIV - 1);
      m_ph = m_t ? 0 : m_ph + 1;
      m_done = 0;
      case (m_st)
        0: if (req_valid) begin
             m_st = 1; m_mem = req_mem; m_wr = req_write; m_wide = req_wide;
             m_addr = req_addr; m_wd = req_wdata;
           end
        1: if (m_t) m_st = 2;
        2: if (m_t) begin m_st = 3; m_n = 0; end
        3: if (m_t) begin
             if (m_n == CMD - 1) begin
               if (!m_wr) begin
                 if (m_wide) m_rd = slv_val;
                 else if (m_addr[0]) m_rd = {8'h00, slv_val[15:8]};
                 else m_rd = {8'h00, slv_val[7:0]};
               end
               m_st = 4;
             end else m_n = m_n + 1;
           end
        4: if (m_t) begin m_st = 0; m_done = 1; end
        default: m_st = 0;
      endcase
    end
  end

  // compare every clock away from the active edge
  always @(negedge clk) begin
    if (running) begin
      bit idle, stb, drv;
      logic [15:0] exp_sd;
      idle = (m_st == 0);
      stb  = (m_st == 3);
      chk(isa_bclk === (m_ph < DIV/2), "R1 bus clock", {31'd0, isa_bclk}, {31'd0, m_ph < DIV/2});
      chk(req_ready === idle, "R3 ready", {31'd0, req_ready}, {31'd0, idle});
      chk(isa_bale === (m_st == 2), "R4 latch enable", {31'd0, isa_bale}, {31'd0, m_st == 2});
      chk({isa_iow_n, isa_ior_n, isa_memw_n, isa_memr_n} ===
          {!(stb && !m_mem && m_wr), !(stb && !m_mem && !m_wr), !(stb && m_mem && m_wr), !(stb && m_mem && !m_wr)},
          idle ? "R2 idle strobes" : "R5 strobe select",
          {28'd0, isa_iow_n, isa_ior_n, isa_memw_n, isa_memr_n},
          {28'd0, !(stb && !m_mem && m_wr), !(stb && !m_mem && !m_wr), !(stb && m_mem && m_wr), !(stb && m_mem && !m_wr)});
      chk(isa_sa === (idle ? 20'd0 : m_addr[19:0]), idle ? "R2 idle address" : "R6 system address",
          {12'd0, isa_sa}, {12'd0, idle ? 20'd0 : m_addr[19:0]});
      chk(isa_la === (idle ? 7'd0 : m_addr[23:17]), "R6 upper address", {25'd0, isa_la}, {25'd0, idle ? 7'd0 : m_addr[23:17]});
      chk(isa_sbhe_n === (idle ? 1'b1 : !(m_wide || m_addr[0])), "R9 upper byte enable",
          {31'd0, isa_sbhe_n}, {31'd0, idle ? 1'b1 : !(m_wide || m_addr[0])});
      chk(rsp_done === m_done, "R10 done pulse", {31'd0, rsp_done}, {31'd0, m_done});
      drv = m_wr && (m_st >= 2);
      if (drv) begin
        if (m_wide) exp_sd = m_wd;
        else if (m_addr[0]) exp_sd = {m_wd[7:0], 8'h00};
        else exp_sd = {8'h00, m_wd[7:0]};
        chk(isa_sd === exp_sd, "R7 write data", {16'd0, isa_sd}, {16'd0, exp_sd});
      end
      if (m_done && !m_wr)
        chk(rsp_rdata === m_rd, "R8 read data", {16'd0, rsp_rdata}, {16'd0, m_rd});
    end
  end

  task automatic run_req(input bit mem, input bit wr, input bit wide, input logic [23:0] a,
                         input logic [15:0] wd, input int gap);
    for (int i = 0; i < gap; i++) @(negedge clk);
    @(negedge clk); #1;
    req_valid = 1; req_mem = mem; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
    @(negedge clk); #1;
    req_valid = 0;
    forever begin
      @(negedge clk);
      if (rsp_done) break;
    end
  endtask

  // a request raised mid-cycle must be ignored (R3)
  task automatic run_with_intrusion;
    @(negedge clk); #1;
    req_valid = 1; req_mem = 1; req_write = 1; req_wide = 1; req_addr = 24'h2A_1234; req_wdata = 16'hBEEF;
    @(negedge clk); #1;
    req_valid = 0;
    repeat (5) @(negedge clk);
    #1;
    req_valid = 1; req_mem = 0; req_write = 0; req_addr = 24'h00_0300;
    @(negedge clk); #1;
    @(negedge clk); #1;
    req_valid = 0;
    forever begin
      @(negedge clk);
      if (rsp_done) break;
    end
    repeat (3 * DIV) begin
      @(negedge clk);
      chk(isa_bale === 1'b0 && req_ready === 1'b1, "R3 ignored request started no cycle",
          {30'd0, isa_bale, req_ready}, 32'd1);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && isa_bale === 1'b0, "R2 in reset ready/latch", {30'd0, req_ready, isa_bale}, 32'd2);
    chk({isa_iow_n, isa_ior_n, isa_memw_n, isa_memr_n} === 4'hF, "R2 in reset strobes",
        {28'd0, isa_iow_n, isa_ior_n, isa_memw_n, isa_memr_n}, 32'hF);
    #1 rst_n = 1;
    running = 1;
    @(negedge clk);
    chk(isa_sbhe_n === 1'b1 && isa_sa === 20'd0, "R2 after reset", {11'd0, isa_sbhe_n, isa_sa}, 32'h100000);

    run_req(0, 1, 1, 24'h00_0378, 16'hA55A, 0);               // I/O word write
    slv_val = 16'hC3E1;
    run_req(0, 0, 0, 24'h00_0301, 16'h0000, 1);               // I/O odd byte read
    run_req(1, 1, 0, 24'hFE_0C71, 16'h00B4, 2);               // memory odd byte write
    slv_val = 16'h1E2D;
    run_req(1, 0, 1, 24'h9A_BCDE, 16'h0000, 3);               // memory word read
    run_req(1, 1, 0, 24'h13_5790, 16'h1266, 0);               // memory even byte write
    slv_val = 16'h7F08;
    run_req(0, 0, 0, 24'h00_0220, 16'h0000, 2);               // I/O even byte read
    for (int k = 0; k < 2 * DIV; k++) begin                   // sweep acceptance phase
      slv_val = 16'h1111 * (k + 1);
      run_req(k[0], k[1], k[2], 24'hF0_0000 + 24'(k * 7), 16'h0F0F ^ 16'(k), k);
    end
    run_with_intrusion();
    repeat (4) @(negedge clk);
    running = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule